// File: doc/BRIEF.md
# Column Drive Pattern Override

This block sits between the display memory and the column drivers of a multiplexed LCD controller. For each row scan it takes the memory word of the current row and decides, by a fixed priority, what each column drives. The choices are forced ground for either of the two sleep controls, all off, all on, a checkerboard, the complement of the checkerboard, or the memory word passed straight through or inverted bit for bit.

The result is captured into the column register only on the row strobe, so the column vector never changes partway through a row. The two sleep controls are the exception. Either one clears the register at the next clock edge with no strobe, because the row timing stops during sleep.

Top module: `col_override`

## Requirements
- R1: While rst_ni is low, and at the first clock edge after its release with no strobe, every bit of cols_o is 0 (off / ground).
- R2: When sleep_cmd_i or sleep_init_i is 1, cols_o is all 0 after the next rising clock edge, whether or not row_strobe_i is high, and whatever the other controls are.
- R3: On a row strobe with both sleep inputs low and blank_i = 1, cols_o becomes all 0. This holds even when set_i, checker_i or inv_checker_i are also 1.
- R4: On a row strobe with no sleep, blank_i = 0 and set_i = 1, cols_o becomes all 1. This holds even when checker_i or inv_checker_i are also 1.
- R5: On a row strobe with no sleep, no blank, no set and checker_i = 1, bit c of cols_o (c counted from 0) is 1 exactly when row_idx_i + c is even. The memory word has no effect.
- R6: With inv_checker_i = 1 and checker_i = 0, and no higher override active, cols_o is the bitwise complement of the R5 pattern. When checker_i and inv_checker_i are both 1, the R5 pattern is used.
- R7: With no override active and video_inv_i = 0, a strobe loads cols_o[c] = mem_word_i[c]. A 1 turns the pixel on and a 0 turns it off.
- R8: With no override active and video_inv_i = 1, a strobe loads cols_o[c] = ~mem_word_i[c].
- R9: Without a strobe and with both sleep inputs low, cols_o holds its value. Changes on mem_word_i, row_idx_i or the override controls have no effect until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| row_strobe_i | input | 1 | One-cycle pulse at a row boundary; loads the column register |
| row_idx_i | input | ROW_W (5) | Index of the row being driven |
| mem_word_i | input | NUM_COLS (116) | Display memory word for the current row |
| blank_i | input | 1 | Force all columns off |
| set_i | input | 1 | Force all columns on |
| sleep_cmd_i | input | 1 | Command sleep; forces ground |
| sleep_init_i | input | 1 | Configuration sleep; forces ground |
| checker_i | input | 1 | Checkerboard pattern |
| inv_checker_i | input | 1 | Inverse checkerboard pattern |
| video_inv_i | input | 1 | 1 inverts the memory word, 0 passes it through |
| cols_o | output | NUM_COLS (116) | Column on/off vector |

## Verification
On every cycle the assertions check that the vector holds between strobes, that sleep grounds it one edge later, and that blank and set dominate at a strobe. They also check that a checker strobe lights exactly half the columns, and that a plain pass-through strobe copies the memory word. Only the bench scenarios can show the exact checker phase against the row index, that the checker pattern wins over the inverse pattern, inverted video, and that memory data is ignored under the patterns. The bench compares whole vectors that it computes itself.

// File: rtl/colovr_pkg.sv
package colovr_pkg;
  typedef enum logic [2:0] {
    SRC_OFF  = 3'd0,
    SRC_ON   = 3'd1,
    SRC_CHK  = 3'd2,
    SRC_ICHK = 3'd3,
    SRC_DATA = 3'd4
  } col_src_e;
endpackage

// File: rtl/colovr_pattern.sv
module colovr_pattern #(
  parameter int NUM_COLS = 116,
  parameter int ROW_W    = 5
) (
  input  logic [ROW_W-1:0]    row_idx_i,
  output logic [NUM_COLS-1:0] chk_o
);
  // pixel lit when row + column is even
  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    assign chk_o[c] = ((row_idx_i + ROW_W'(c)) & ROW_W'(1)) == '0;
  end
endmodule

// File: rtl/colovr_select.sv
module colovr_select
  import colovr_pkg::*;
#(
  parameter int NUM_COLS = 116
) (
  input  logic [NUM_COLS-1:0] mem_word_i,
  input  logic [NUM_COLS-1:0] chk_i,
  input  logic                blank_i,
  input  logic                set_i,
  input  logic                checker_i,
  input  logic                inv_checker_i,
  input  logic                video_inv_i,
  output logic [NUM_COLS-1:0] cols_o
);
  col_src_e src;

  always_comb begin
    if (blank_i)            src = SRC_OFF;
    else if (set_i)         src = SRC_ON;
    else if (checker_i)     src = SRC_CHK;
    else if (inv_checker_i) src = SRC_ICHK;
    else                    src = SRC_DATA;
  end

  always_comb begin
    unique case (src)
      SRC_OFF:  cols_o = '0;
      SRC_ON:   cols_o = '1;
      SRC_CHK:  cols_o = chk_i;
      SRC_ICHK: cols_o = ~chk_i;
      default:  cols_o = video_inv_i ? ~mem_word_i : mem_word_i;
    endcase
  end
endmodule

// File: rtl/colovr_hold.sv
module colovr_hold #(
  parameter int NUM_COLS = 116
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ground_i,
  input  logic                load_i,
  input  logic [NUM_COLS-1:0] d_i,
  output logic [NUM_COLS-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q_o <= '0;
    else if (ground_i) q_o <= '0;
    else if (load_i)   q_o <= d_i;
  end
endmodule

// File: rtl/col_override.sv
module col_override #(
  parameter int NUM_COLS = 116,
  parameter int ROW_W    = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                row_strobe_i,
  input  logic [ROW_W-1:0]    row_idx_i,
  input  logic [NUM_COLS-1:0] mem_word_i,
  input  logic                blank_i,
  input  logic                set_i,
  input  logic                sleep_cmd_i,
  input  logic                sleep_init_i,
  input  logic                checker_i,
  input  logic                inv_checker_i,
  input  logic                video_inv_i,
  output logic [NUM_COLS-1:0] cols_o
);
  logic [NUM_COLS-1:0] chk;
  logic [NUM_COLS-1:0] next_cols;
  logic                ground;

  assign ground = sleep_cmd_i | sleep_init_i;

  colovr_pattern #(.NUM_COLS(NUM_COLS), .ROW_W(ROW_W)) u_pattern (
    .row_idx_i (row_idx_i),
    .chk_o     (chk)
  );

  colovr_select #(.NUM_COLS(NUM_COLS)) u_select (
    .mem_word_i    (mem_word_i),
    .chk_i         (chk),
    .blank_i       (blank_i),
    .set_i         (set_i),
    .checker_i     (checker_i),
    .inv_checker_i (inv_checker_i),
    .video_inv_i   (video_inv_i),
    .cols_o        (next_cols)
  );

  colovr_hold #(.NUM_COLS(NUM_COLS)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ground_i (ground),
    .load_i   (row_strobe_i),
    .d_i      (next_cols),
    .q_o      (cols_o)
  );
endmodule

// File: rtl/colovr_chk.sv
module colovr_chk #(
  parameter int NUM_COLS = 116,
  parameter int ROW_W    = 5
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                row_strobe_i,
  input logic [ROW_W-1:0]    row_idx_i,
  input logic [NUM_COLS-1:0] mem_word_i,
  input logic                blank_i,
  input logic                set_i,
  input logic                sleep_cmd_i,
  input logic                sleep_init_i,
  input logic                checker_i,
  input logic                inv_checker_i,
  input logic                video_inv_i,
  input logic [NUM_COLS-1:0] cols_o
);
  logic asleep;
  assign asleep = sleep_cmd_i | sleep_init_i;

  // R9
  hold_between_strobes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!row_strobe_i && !asleep) |=> $stable(cols_o));

  // R2
  sleep_grounds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    asleep |=> (cols_o == '0));

  // R3
  blank_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_strobe_i && !asleep && blank_i) |=> (cols_o == '0));

  // R4
  set_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_strobe_i && !asleep && !blank_i && set_i) |=> (cols_o == '1));

  // R5
  checker_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_strobe_i && !asleep && !blank_i && !set_i && checker_i)
      |=> ($countones(cols_o) == ((NUM_COLS + 1 - (NUM_COLS % 2) * 32'(row_idx_i[0])) / 2)));

  // R7
  pass_through_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_strobe_i && !asleep && !blank_i && !set_i && !checker_i && !inv_checker_i && !video_inv_i)
      |=> (cols_o == $past(mem_word_i)));
endmodule

bind col_override colovr_chk #(.NUM_COLS(NUM_COLS), .ROW_W(ROW_W)) u_colovr_chk (.*);

// File: tb/col_override_test.sv
module col_override_test;
  localparam int NC = 116;
  localparam int RW = 5;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          row_strobe_i = 1'b0;
  logic [RW-1:0] row_idx_i = '0;
  logic [NC-1:0] mem_word_i = '0;
  logic          blank_i = 1'b0, set_i = 1'b0, sleep_cmd_i = 1'b0, sleep_init_i = 1'b0;
  logic          checker_i = 1'b0, inv_checker_i = 1'b0, video_inv_i = 1'b0;
  logic [NC-1:0] cols_o;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  col_override #(.NUM_COLS(NC), .ROW_W(RW)) uut (.*);

  function automatic logic [NC-1:0] chk_pat(int row);
    logic [NC-1:0] v;
    for (int c = 0; c < NC; c++) v[c] = ((row + c) % 2) == 0;
    return v;
  endfunction

  function automatic logic [NC-1:0] mk_word(int seed);
    logic [NC-1:0] v;
    for (int c = 0; c < NC; c++) v[c] = ((c * 7 + seed * 13 + (c / 5)) % 3) == 0;
    return v;
  endfunction

  task automatic check(string req, logic [NC-1:0] exp);
    checks++;
    if (cols_o !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, cols_o, exp);
    end
  endtask

  task automatic clear_ctrl();
    blank_i = 0; set_i = 0; sleep_cmd_i = 0; sleep_init_i = 0;
    checker_i = 0; inv_checker_i = 0; video_inv_i = 0;
  endtask

  // drive at negedge, strobe for one edge, sample at following negedge
  task automatic strobe(int row, logic [NC-1:0] word);
    row_idx_i = RW'(row);
    mem_word_i = word;
    row_strobe_i = 1'b1;
    @(negedge clk_i);
    row_strobe_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", '0);
  endtask

  task automatic t_pass();
    clear_ctrl();
    strobe(3, mk_word(1));
    check("R7", mk_word(1));
    strobe(4, '1);
    check("R7", '1);
  endtask

  task automatic t_video();
    clear_ctrl();
    video_inv_i = 1;
    strobe(5, mk_word(2));
    check("R8", ~mk_word(2));
    video_inv_i = 0;
  endtask

  task automatic t_hold();
    clear_ctrl();
    strobe(1, mk_word(3));
    mem_word_i = mk_word(4);
    row_idx_i = 7;
    set_i = 1;
    video_inv_i = 1;
    repeat (3) @(negedge clk_i);
    check("R9", mk_word(3));
  endtask

  task automatic t_checker();
    clear_ctrl();
    checker_i = 1;
    strobe(0, mk_word(5));
    check("R5", chk_pat(0));
    strobe(1, '1);
    check("R5", chk_pat(1));
    strobe(22, '0);
    check("R5", chk_pat(22));
    inv_checker_i = 1;
    strobe(9, mk_word(6));
    check("R6", chk_pat(9));
    checker_i = 0;
    strobe(9, mk_word(6));
    check("R6", ~chk_pat(9));
    strobe(2, '1);
    check("R6", ~chk_pat(2));
  endtask

  task automatic t_set_blank();
    clear_ctrl();
    set_i = 1; checker_i = 1;
    strobe(0, '0);
    check("R4", '1);
    blank_i = 1;
    strobe(0, '1);
    check("R3", '0);
  endtask

  task automatic t_sleep();
    clear_ctrl();
    strobe(2, '1);
    check("R7", '1);
    sleep_cmd_i = 1;
    @(negedge clk_i);
    check("R2", '0);
    sleep_cmd_i = 0;
    strobe(2, '1);
    check("R7", '1);
    sleep_init_i = 1; set_i = 1;
    strobe(2, '1);
    check("R2", '0);
    sleep_init_i = 0; set_i = 0;
  endtask

  initial begin
    #4000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    t_reset();
    t_pass();
    t_video();
    t_hold();
    t_checker();
    t_set_blank();
    t_sleep();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule